// File: doc/BRIEF.md
# SPI Register-Access Slave

This block lets an external SPI master read and write a bank of 8-bit registers. It works in SPI mode 3. SCK idles high, and the block samples MOSI on the rising edge. It drives MISO on the falling edge. Every chip-select frame opens with a command byte. The top bit of that byte picks the direction and the low seven bits give the starting register. Data bytes follow with no limit on their number. The address steps forward after each byte and wraps back to zero at the top of the bank.

All SPI inputs are oversampled in the system clock domain through two-flop synchronizers. SCK edges are found by comparing the synchronized value with its previous sample.

- The clock must run at least four times faster than SCK for edge detection.
- For reads, each SCK low phase must also last more than four system clocks, because MISO settles about four clocks after the falling edge.
- MISO is driven only in the data phase of a read frame. At all other times its enable is low and a board pull-up returns ones to the master.

On-chip logic reads and writes the same registers through a local port.

The controller is a four-state machine:

- **IDLE**: chip select is high.
- **CMD**: the command byte is being shifted in.
- **WRITE**: data bytes are being stored.
- **READ**: data bytes are being shifted out.

Transitions:

- *select*: IDLE to CMD while CS is low.
- *cmd_write*: CMD to WRITE when the eighth command bit completes with a top bit of 0.
- *cmd_read*: CMD to READ when it completes with a top bit of 1.
- *deselect*: any state to IDLE when the synchronized CS is high.

Top module: `spi_regbank_slave`

## Requirements
- R1: After reset every register reads 0x00, the MISO enable is low and the controller is in IDLE.
- R2: MOSI is captured on rising SCK edges, MSB first. In the first byte of a frame, bit 7 = 0 selects a write and bit 7 = 1 selects a read. Bits 6..0 give the starting register address.
- R3: In a write frame, each complete data byte after the command is stored at the current address. The address then increments and wraps from 127 to 0.
- R4: The MISO enable stays low during the command byte, during a write frame and while CS is high, so the master samples 0xFF. It rises only right after the rising edge that completes a read command.
- R5: In a read frame, MISO presents the register at the current address MSB first, starting with the falling SCK edge after the command byte. MISO changes only on falling SCK edges. Later bytes come from incrementing addresses that wrap from 127 to 0.
- R6: CS going high ends the frame. A partly received data byte is not stored, and the next frame starts again with a command byte.
- R7: `loc_rdata` shows the register selected by `loc_addr` combinationally. `loc_we` stores `loc_wdata` at that address on the next clock edge, and the new value is then readable over SPI.
- R8: When an SPI write and a local write hit the same register in the same clock cycle, the SPI byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock, idles high |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| loc_we | input | 1 | Local write strobe |
| loc_addr | input | 7 | Local register address |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Local read data |

## Verification
The bound checker watches several properties on every cycle:

- MISO changes only in the cycle after a detected falling SCK edge.
- The MISO enable rises only after a detected rising edge.
- Register writes from SPI coincide with a rising edge and never happen while deselected.
- A deasserted CS returns the controller to IDLE.
- A write frame never turns into a read frame.

Only the bench's scenarios can show data correctness: burst contents, the address wrap in both directions, that a partial byte is dropped after an abort, and that the SPI side wins a same-cycle collision.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CMD   = 2'd1,
        ST_WRITE = 2'd2,
        ST_READ  = 2'd3
    } spi_rb_state_t;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_rb_regfile.sv
module spi_rb_regfile #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_we,
    input  logic [ADDR_W-1:0] spi_waddr,
    input  logic [DATA_W-1:0] spi_wdata,
    input  logic [ADDR_W-1:0] spi_raddr,
    output logic [DATA_W-1:0] spi_rdata,
    input  logic              loc_we,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic [DATA_W-1:0] loc_wdata,
    output logic [DATA_W-1:0] loc_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (spi_we && spi_waddr == ADDR_W'(i))
                mem[i] <= spi_wdata;          // SPI side has priority
            else if (loc_we && loc_addr == ADDR_W'(i))
                mem[i] <= loc_wdata;
        end
    end

    assign spi_rdata = mem[spi_raddr];
    assign loc_rdata = mem[loc_addr];
endmodule

// File: rtl/spi_rb_ctrl.sv
module spi_rb_ctrl
    import spi_rb_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi_s,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              miso,
    output logic              miso_oe,
    output spi_rb_state_t     state
);
    localparam int CNT_W = 3;
    localparam logic [CNT_W-1:0] LAST_BIT = '1;

    spi_rb_state_t     state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic [6:0]        shreg;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        tx_q;
    logic              miso_q;
    logic              active;
    logic              byte_done;
    logic [7:0]        rx_byte;

    assign active    = !cs_s && (state_q != ST_IDLE);
    assign byte_done = active && sck_rise && (bit_cnt == LAST_BIT);
    assign rx_byte   = {shreg, mosi_s};

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cs_s) begin
            state_d = ST_IDLE;                       // deselect
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_CMD;          // select
                ST_CMD:   if (byte_done)
                              state_d = rx_byte[7] ? ST_READ : ST_WRITE;
                ST_WRITE: state_d = ST_WRITE;
                ST_READ:  state_d = ST_READ;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            addr_q  <= '0;
            tx_q    <= '0;
            miso_q  <= 1'b1;
        end else if (!active) begin
            bit_cnt <= '0;
        end else begin
            if (sck_rise) begin
                shreg   <= rx_byte[6:0];
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST_BIT) begin
                    unique case (state_q)
                        ST_CMD: begin
                            if (rx_byte[7]) begin
                                tx_q   <= rd_data;
                                addr_q <= rx_byte[ADDR_W-1:0] + 1'b1;
                            end else begin
                                addr_q <= rx_byte[ADDR_W-1:0];
                            end
                        end
                        ST_WRITE: addr_q <= addr_q + 1'b1;
                        ST_READ: begin
                            tx_q   <= rd_data;
                            addr_q <= addr_q + 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            if (sck_fall && state_q == ST_READ) begin
                miso_q <= tx_q[7];
                tx_q   <= {tx_q[6:0], 1'b0};
            end
        end
    end

    assign rd_addr = (state_q == ST_CMD) ? rx_byte[ADDR_W-1:0] : addr_q;
    assign wr_en   = byte_done && (state_q == ST_WRITE);
    assign wr_addr = addr_q;
    assign wr_data = rx_byte;
    assign miso    = miso_q;
    assign miso_oe = (state_q == ST_READ) && !cs_s;
    assign state   = state_q;
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
    import spi_rb_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic              loc_we,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic [7:0]        loc_wdata,
    output logic [7:0]        loc_rdata
);
    logic              sck_s, cs_s, mosi_s, sck_d;
    logic              sck_rise, sck_fall;
    logic              spi_we;
    logic [ADDR_W-1:0] spi_waddr, spi_raddr;
    logic [7:0]        spi_wdata, spi_rdata;
    spi_rb_state_t     st;

    spi_rb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_sck, spi_cs_n, spi_mosi}),
        .q     ({sck_s, cs_s, mosi_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b1;
        else        sck_d <= sck_s;
    end

    assign sck_rise = sck_s && !sck_d;
    assign sck_fall = !sck_s && sck_d;

    spi_rb_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_s     (cs_s),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .mosi_s   (mosi_s),
        .rd_data  (spi_rdata),
        .rd_addr  (spi_raddr),
        .wr_en    (spi_we),
        .wr_addr  (spi_waddr),
        .wr_data  (spi_wdata),
        .miso     (spi_miso),
        .miso_oe  (spi_miso_oe),
        .state    (st)
    );

    spi_rb_regfile #(.ADDR_W(ADDR_W), .DATA_W(8)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_we    (spi_we),
        .spi_waddr (spi_waddr),
        .spi_wdata (spi_wdata),
        .spi_raddr (spi_raddr),
        .spi_rdata (spi_rdata),
        .loc_we    (loc_we),
        .loc_addr  (loc_addr),
        .loc_wdata (loc_wdata),
        .loc_rdata (loc_rdata)
    );
endmodule

// File: rtl/spi_rb_checker.sv
module spi_rb_checker
    import spi_rb_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          cs_s,
    input logic          sck_rise,
    input logic          sck_fall,
    input logic          spi_we,
    input logic          spi_miso,
    input logic          spi_miso_oe,
    input spi_rb_state_t st
);
    // R5: MISO only moves after a detected falling SCK edge
    a_r5_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(spi_miso));

    // R4: the MISO driver turns on only right after a rising edge (end of read command)
    a_r4_oe_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_miso_oe) |-> $past(sck_rise));

    // R3: SPI register writes coincide with a detected rising SCK edge
    a_r3_write_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        spi_we |-> sck_rise);

    // R6: no write while deselected, and deselect returns to IDLE
    a_r6_no_write_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |-> !spi_we);
    a_r6_cs_abort: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (st == ST_IDLE));

    // R2: a frame decoded as write never turns into a read
    a_r2_frame_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WRITE) |=> (st != ST_READ));
endmodule

bind spi_regbank_slave spi_rb_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_s        (cs_s),
    .sck_rise    (sck_rise),
    .sck_fall    (sck_fall),
    .spi_we      (spi_we),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe),
    .st          (st)
);

// File: tb/spi_regbank_slave_tb_top.sv
`timescale 1ns/1ps
module spi_regbank_slave_tb_top;
    localparam int HALF = 6;   // SCK half period in clk cycles

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b1, spi_cs_n = 1'b1, spi_mosi = 1'b1;
    logic       spi_miso, spi_miso_oe;
    logic       loc_we = 1'b0;
    logic [6:0] loc_addr = '0;
    logic [7:0] loc_wdata = '0;
    logic [7:0] loc_rdata;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    spi_regbank_slave dut_i (
        .clk (clk), .rst_n (rst_n),
        .spi_sck (spi_sck), .spi_cs_n (spi_cs_n), .spi_mosi (spi_mosi),
        .spi_miso (spi_miso), .spi_miso_oe (spi_miso_oe),
        .loc_we (loc_we), .loc_addr (loc_addr),
        .loc_wdata (loc_wdata), .loc_rdata (loc_rdata)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_open();
        spi_cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic frame_close();
        tick(HALF);
        spi_cs_n = 1'b1;
        tick(4 * HALF);
    endtask

    // shifts nbits of tx; returns what the master sees (pull-up when not driven)
    task automatic xfer(input logic [7:0] tx, input int nbits, input bit collide,
                        input logic [7:0] cdata, output logic [7:0] rx);
        rx = 8'hFF;
        for (int i = 0; i < nbits; i++) begin
            spi_sck  = 1'b0;
            spi_mosi = tx[7-i];
            tick(HALF);
            rx[7-i] = spi_miso_oe ? spi_miso : 1'b1;
            spi_sck = 1'b1;
            if (collide && i == 7) begin
                tick(1);
                loc_we = 1'b1; loc_wdata = cdata;
                tick(2);
                loc_we = 1'b0;
                tick(HALF - 3);
            end else begin
                tick(HALF);
            end
        end
    endtask

    task automatic loc_peek(input int a, output logic [7:0] v);
        loc_addr = 7'(a);
        #1;
        v = loc_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx, v;
        tick(3);
        rst_n = 1'b1;
        tick(3);

        // R1: reset state
        chk("R1 oe", {7'b0, spi_miso_oe}, 8'h00);
        for (int a = 0; a < 128; a++) begin
            loc_peek(a, v);
            chk("R1 reg", v, 8'h00);
        end

        // R2/R3/R4: full-bank burst write starting at 5, wrapping past 127
        frame_open();
        xfer(8'h05, 8, 1'b0, 8'h00, rx);
        chk("R4 cmd miso", rx, 8'hFF);
        for (int k = 0; k < 128; k++) begin
            xfer(pat((5 + k) & 127), 8, 1'b0, 8'h00, rx);
            chk("R4 write miso", rx, 8'hFF);
        end
        frame_close();
        for (int a = 0; a < 128; a++) begin
            loc_peek(a, v);
            chk("R3 burst write", v, pat(a));
        end

        // R5: burst read from 120, wraps to 0
        frame_open();
        xfer(8'h80 | 8'd120, 8, 1'b0, 8'h00, rx);
        chk("R4 read cmd miso", rx, 8'hFF);
        for (int k = 0; k < 16; k++) begin
            xfer(8'h00, 8, 1'b0, 8'h00, rx);
            chk("R5 burst read", rx, pat((120 + k) & 127));
        end
        frame_close();
        chk("R4 oe after frame", {7'b0, spi_miso_oe}, 8'h00);

        // R2: single reads at several addresses
        for (int j = 0; j < 4; j++) begin
            int a;
            a = (j == 3) ? 127 : j * 42;
            frame_open();
            xfer(8'h80 | 8'(a), 8, 1'b0, 8'h00, rx);
            xfer(8'h00, 8, 1'b0, 8'h00, rx);
            frame_close();
            chk("R2 single read", rx, pat(a));
        end

        // R6: abort with a partial byte
        frame_open();
        xfer(8'h0A, 8, 1'b0, 8'h00, rx);
        xfer(8'hAA, 8, 1'b0, 8'h00, rx);
        xfer(8'h55, 5, 1'b0, 8'h00, rx);
        frame_close();
        loc_peek(10, v);
        chk("R3 full byte kept", v, 8'hAA);
        loc_peek(11, v);
        chk("R6 partial dropped", v, pat(11));
        frame_open();
        xfer(8'h8B, 8, 1'b0, 8'h00, rx);
        xfer(8'h00, 8, 1'b0, 8'h00, rx);
        frame_close();
        chk("R6 fresh frame", rx, pat(11));

        // R7: local write visible locally and over SPI
        loc_addr = 7'd50; loc_wdata = 8'h3C; loc_we = 1'b1;
        tick(1);
        loc_we = 1'b0;
        loc_peek(50, v);
        chk("R7 local rd", v, 8'h3C);
        frame_open();
        xfer(8'h80 | 8'd50, 8, 1'b0, 8'h00, rx);
        xfer(8'h00, 8, 1'b0, 8'h00, rx);
        frame_close();
        chk("R7 spi rd", rx, 8'h3C);

        // R8: same-cycle collision, SPI wins
        loc_addr = 7'd60;
        frame_open();
        xfer(8'd60, 8, 1'b0, 8'h00, rx);
        xfer(8'h99, 8, 1'b1, 8'h66, rx);
        frame_close();
        loc_peek(60, v);
        chk("R8 collision", v, 8'h99);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule